// File: doc/BRIEF.md
# Byte Serializer/Deserializer with Loopback Steering

This block is the digital core of a byte-wide serial link port. One clock runs at the bit rate. A divide-by-8 counter derives the byte clock from it. On the transmit side a byte and its even-parity bit are captured at each byte-clock rising edge. The parity is checked, and the byte is shifted out serially with the most significant bit first. On the receive side, serial bits are collected into bytes at boundaries that an external align strobe marks. Each output byte carries a freshly generated parity bit.

Two control inputs steer the serial paths around the converters. Facility loopback sends received serial data straight back out. Equipment loopback feeds the transmit serial stream into the deserializer. With both inputs high, the block runs in split mode. Clock synthesis, clock recovery, line drivers and frame search are outside this block.

Top module: `serdes_lpbk_top`

## Requirements
- R1: While `rst_n` is low, `byte_clk` is 1 and `ser_tx`, `tx_par_err`, `rx_byte` and `rx_par` are 0.
- R2: On the clock edge where `byte_clk` rises, `tx_byte` and `tx_par` are captured. From that edge on, `ser_tx` carries the captured byte MSB first, one bit per clock, for 8 clocks.
- R3: `byte_clk` is the bit clock divided by 8. After reset it is high for 4 clocks and then low for 4 clocks, and this repeats. It rises 8 clocks after reset is released.
- R4: Even parity is used: a byte is correct when `tx_par` equals the XOR of its 8 data bits. The mismatch of a captured byte appears on `tx_par_err` at the next byte-clock rising edge. `tx_par_err` holds that value until the following rising edge.
- R5: `rx_par` is always the XOR of the bits of `rx_byte`, and it changes in the same clock as `rx_byte`.
- R6: `ser_rx` and `rx_align` are registered for one clock. If `rx_align` is high together with a bit on `ser_rx`, that bit is the LSB of a byte. One clock later, `rx_byte` shows that bit together with the 7 bits before it, the oldest bit in the MSB.
- R7: While `fac_lpbk` is high and `eqp_lpbk` is low, `ser_tx` equals `ser_rx` delayed by one clock. The receive path still deserializes `ser_rx` as in R6.
- R8: While `eqp_lpbk` is high and `fac_lpbk` is low, `ser_tx` still carries transmit data as in R2. The deserializer takes the transmit serial stream instead of `ser_rx`, and `rx_align` is ignored. A byte captured at one byte-clock rising edge appears on `rx_byte` exactly 8 clocks later.
- R9: While both loopback inputs are high, `ser_tx` follows `ser_rx` as in R7, and `rx_byte` shows the transmitted bytes as in R8.
- R10: Asserting `rst_n` low in the middle of a byte returns every output to its R1 value. Operation then restarts as from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_byte | input | 8 | Parallel transmit byte |
| tx_par | input | 1 | Even parity bit for `tx_byte` |
| fac_lpbk | input | 1 | Route serial receive data to serial transmit output |
| eqp_lpbk | input | 1 | Route serial transmit data into the deserializer |
| ser_rx | input | 1 | Serial receive data |
| rx_align | input | 1 | Marks the LSB of a receive byte on `ser_rx` |
| byte_clk | output | 1 | Bit clock divided by 8 |
| ser_tx | output | 1 | Serial transmit data |
| tx_par_err | output | 1 | Parity mismatch of the previously captured byte |
| rx_byte | output | 8 | Parallel receive byte |
| rx_par | output | 1 | Even parity of `rx_byte` |

## Verification
The bench builds the block with its default byte width of 8. With that width the byte clock wraps every 8 cycles, so a few hundred cycles cover many capture edges in each of the four steering modes. Random bytes are sent with parity corrupted about a third of the time. The receive align strobe is placed at a byte offset that does not match the transmit framing, which shows that normal and facility modes take their boundaries from the strobe and not from the divider. A reset in the middle of a byte and mode changes part-way through a byte reach the restart and re-framing corners.

// File: rtl/serdes_lb_pkg.sv
package serdes_lb_pkg;

  // Steering mode: bit 1 = equipment loop, bit 0 = facility loop
  typedef enum logic [1:0] {
    LB_NONE  = 2'b00,
    LB_FAC   = 2'b01,
    LB_EQP   = 2'b10,
    LB_SPLIT = 2'b11
  } lb_mode_e;

  function automatic lb_mode_e lb_decode(input logic fac, input logic eqp);
    return lb_mode_e'({eqp, fac});
  endfunction

endpackage

// File: rtl/sdl_bytediv.sv
module sdl_bytediv #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic byte_clk,
  output logic load_stb
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (cnt_q == CW'(W-1)) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign load_stb = (cnt_q == CW'(W-1));
  assign byte_clk = ~cnt_q[CW-1];

  // R3
  byte_clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> $rose(byte_clk));

endmodule

// File: rtl/sdl_txser.sv
module sdl_txser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_stb,
  input  logic [W-1:0] tx_byte,
  input  logic         tx_par,
  output logic         ser_bit,
  output logic         par_err
);
  logic [W-1:0] shift_q, shift_d;
  logic [W-1:0] cap_q, cap_d;
  logic         cap_par_q, cap_par_d;
  logic         err_q, err_d;

  always_comb begin
    shift_d   = {shift_q[W-2:0], 1'b0};
    cap_d     = cap_q;
    cap_par_d = cap_par_q;
    err_d     = err_q;
    if (load_stb) begin
      shift_d   = tx_byte;
      cap_d     = tx_byte;
      cap_par_d = tx_par;
      err_d     = (^cap_q) ^ cap_par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      cap_q     <= '0;
      cap_par_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      shift_q   <= shift_d;
      cap_q     <= cap_d;
      cap_par_q <= cap_par_d;
      err_q     <= err_d;
    end
  end

  assign ser_bit = shift_q[W-1];
  assign par_err = err_q;

  // R2
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (ser_bit == $past(tx_byte[W-1])));

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |=> $stable(par_err));

endmodule

// File: rtl/sdl_rxdes.sv
module sdl_rxdes #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         align_in,
  input  logic         des_bit,
  input  logic         frame_stb,
  input  logic         eqp_sel,
  output logic         rx_bit_q,
  output logic [W-1:0] rx_byte,
  output logic         rx_par
);
  logic           in_q, align_q;
  logic [W-2:0]   hist_q, hist_d;
  logic [W-1:0]   byte_q, byte_d;
  logic           par_q, par_d;
  logic           strobe;

  assign strobe = eqp_sel ? frame_stb : align_q;

  always_comb begin
    hist_d = {hist_q[W-3:0], des_bit};
    byte_d = byte_q;
    par_d  = par_q;
    if (strobe) begin
      byte_d = {hist_q, des_bit};
      par_d  = ^{hist_q, des_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      align_q <= 1'b0;
      hist_q  <= '0;
      byte_q  <= '0;
      par_q   <= 1'b0;
    end else begin
      in_q    <= ser_in;
      align_q <= align_in;
      hist_q  <= hist_d;
      byte_q  <= byte_d;
      par_q   <= par_d;
    end
  end

  assign rx_bit_q = in_q;
  assign rx_byte  = byte_q;
  assign rx_par   = par_q;

  // R5
  rx_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_par == ^rx_byte);

  // R6
  rx_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (rx_byte[0] == $past(des_bit)));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(rx_byte));

endmodule

// File: rtl/sdl_lbsteer.sv
module sdl_lbsteer
  import serdes_lb_pkg::*;
(
  input  lb_mode_e mode,
  input  logic     tx_bit,
  input  logic     rx_bit,
  output logic     ser_out,
  output logic     des_in
);
  always_comb begin
    ser_out = tx_bit;
    des_in  = rx_bit;
    unique case (mode)
      LB_NONE:  begin ser_out = tx_bit; des_in = rx_bit; end
      LB_FAC:   begin ser_out = rx_bit; des_in = rx_bit; end
      LB_EQP:   begin ser_out = tx_bit; des_in = tx_bit; end
      LB_SPLIT: begin ser_out = rx_bit; des_in = tx_bit; end
      default:  begin ser_out = tx_bit; des_in = rx_bit; end
    endcase
  end
endmodule

// File: rtl/serdes_lpbk_top.sv
module serdes_lpbk_top
  import serdes_lb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_byte,
  input  logic         tx_par,
  input  logic         fac_lpbk,
  input  logic         eqp_lpbk,
  input  logic         ser_rx,
  input  logic         rx_align,
  output logic         byte_clk,
  output logic         ser_tx,
  output logic         tx_par_err,
  output logic [W-1:0] rx_byte,
  output logic         rx_par
);
  logic     load_stb;
  logic     tx_bit, rx_bit, des_bit;
  lb_mode_e mode;
  logic     live_q;

  assign mode = lb_decode(fac_lpbk, eqp_lpbk);

  sdl_bytediv #(.W(W)) i_div (
    .clk(clk), .rst_n(rst_n), .byte_clk(byte_clk), .load_stb(load_stb)
  );

  sdl_txser #(.W(W)) i_tx (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .tx_byte(tx_byte),
    .tx_par(tx_par), .ser_bit(tx_bit), .par_err(tx_par_err)
  );

  sdl_lbsteer i_steer (
    .mode(mode), .tx_bit(tx_bit), .rx_bit(rx_bit),
    .ser_out(ser_tx), .des_in(des_bit)
  );

  sdl_rxdes #(.W(W)) i_rx (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_rx), .align_in(rx_align),
    .des_bit(des_bit), .frame_stb(load_stb), .eqp_sel(eqp_lpbk),
    .rx_bit_q(rx_bit), .rx_byte(rx_byte), .rx_par(rx_par)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // R7
  fac_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && fac_lpbk) |-> (ser_tx == $past(ser_rx)));

endmodule

// File: tb/test_serdes_lpbk_top.sv
module test_serdes_lpbk_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_byte;
  logic       tx_par, fac_lpbk, eqp_lpbk, ser_rx, rx_align;
  logic       byte_clk, ser_tx, tx_par_err, rx_par;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serdes_lpbk_top i_serdes_lpbk_top (
    .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_par(tx_par),
    .fac_lpbk(fac_lpbk), .eqp_lpbk(eqp_lpbk), .ser_rx(ser_rx),
    .rx_align(rx_align), .byte_clk(byte_clk), .ser_tx(ser_tx),
    .tx_par_err(tx_par_err), .rx_byte(rx_byte), .rx_par(rx_par)
  );

  // Behavioural reference
  int         phase;
  bit         txq[$];
  bit         hist[$];
  logic       m_cur, m_err, m_pend, m_rxq, m_alq, m_rxp;
  logic [7:0] m_rxb;

  task automatic model_clear();
    phase = 0; txq.delete(); hist.delete();
    for (int i = 0; i < 7; i++) hist.push_back(1'b0);
    m_cur = 0; m_err = 0; m_pend = 0; m_rxq = 0; m_alq = 0;
    m_rxb = 8'h00; m_rxp = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else begin
      logic din, stb;
      din = eqp_lpbk ? m_cur : m_rxq;
      stb = eqp_lpbk ? (phase == 7) : m_alq;
      if (stb) begin
        for (int i = 0; i < 7; i++) m_rxb[7-i] = hist[i];
        m_rxb[0] = din;
        m_rxp = ^m_rxb;
      end
      hist.push_back(din);
      void'(hist.pop_front());
      if (phase == 7) begin
        m_err  = m_pend;
        m_pend = (^tx_byte) ^ tx_par;
        txq.delete();
        for (int i = 6; i >= 0; i--) txq.push_back(tx_byte[i]);
        m_cur = tx_byte[7];
      end else begin
        m_cur = (txq.size() > 0) ? txq.pop_front() : 1'b0;
      end
      m_rxq = ser_rx;
      m_alq = rx_align;
      phase = (phase + 1) % 8;
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_reset(input string req);
    chk(req, "byte_clk", {7'd0, byte_clk}, 8'd1);
    chk(req, "ser_tx", {7'd0, ser_tx}, 8'd0);
    chk(req, "tx_par_err", {7'd0, tx_par_err}, 8'd0);
    chk(req, "rx_byte", rx_byte, 8'd0);
    chk(req, "rx_par", {7'd0, rx_par}, 8'd0);
  endtask

  task automatic check_all();
    string rs, rb;
    logic  es;
    case ({eqp_lpbk, fac_lpbk})
      2'b01:   begin rs = "R7"; rb = "R6"; end
      2'b10:   begin rs = "R2"; rb = "R8"; end
      2'b11:   begin rs = "R9"; rb = "R9"; end
      default: begin rs = "R2"; rb = "R6"; end
    endcase
    es = fac_lpbk ? m_rxq : m_cur;
    chk("R3", "byte_clk", {7'd0, byte_clk}, {7'd0, phase < 4});
    chk(rs, "ser_tx", {7'd0, ser_tx}, {7'd0, es});
    chk("R4", "tx_par_err", {7'd0, tx_par_err}, {7'd0, m_err});
    chk(rb, "rx_byte", rx_byte, m_rxb);
    chk("R5", "rx_par", {7'd0, rx_par}, {7'd0, m_rxp});
  endtask

  int rxk;

  task automatic drive();
    logic [7:0] b;
    b = 8'($urandom);
    tx_byte  = b;
    tx_par   = (^b) ^ (($urandom % 3) == 0);
    ser_rx   = 1'($urandom);
    rx_align = ((rxk % 8) == 7);
    rxk++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      drive();
    end
  endtask

  initial begin
    rst_n = 0; fac_lpbk = 0; eqp_lpbk = 0; rxk = 3;
    tx_byte = 0; tx_par = 0; ser_rx = 0; rx_align = 0;
    repeat (3) @(negedge clk);
    check_reset("R1");
    rst_n = 1;
    run(200);                         // R2 R3 R4 R6 normal
    fac_lpbk = 1; run(200);           // R7
    fac_lpbk = 0; eqp_lpbk = 1; run(200);  // R8
    fac_lpbk = 1; run(200);           // R9
    fac_lpbk = 0; eqp_lpbk = 0; run(13);
    #(CLK_PERIOD/4) rst_n = 0;        // R10 mid-byte reset
    @(negedge clk);
    check_reset("R10");
    rst_n = 1;
    run(100);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule